// File: doc/BRIEF.md
# Memory Geometry Auto-Detect Sequencer

This block runs once after memory start-up to find how many row address bits and how many column address bits the attached memory has. It does not read a descriptor. It puts the memory controller into a deliberately oversized configuration and then looks for the lowest address that wraps back onto address zero. Every access goes through an external alias-test port. The block raises a one-cycle probe request with an address, and the port replies with a done strobe and a match flag. The flag is set when the probe address reads back as a mirror of address zero.

The search has two phases. The row phase uses a small page and the largest row count. It tries row counts in ascending order, and the first one that aliases is the answer. The column phase uses the smallest row count and the largest page. It tries page exponents in the same way. When both phases are done, the block applies a final configuration. This final word has sequential mode off, the caller's rank code restored, and the detected geometry. In the same cycle it pulses `done_o`, and from then on it presents the page size and the total capacity in bytes.

Top module: `geo_probe_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, probe_req_o and cfg_apply_o are all 0.
- R2: The configuration word is laid out as follows. Bit 0 is sequential mode. Bits 2:1 are the rank code. Bits 7:3 are the row count. Bits 11:8 are the page-size exponent. Bit 12 is the bank code. Bit 13 is 1 for a 16-bit bus. A word takes effect in each cycle where cfg_apply_o is 1. Each run applies exactly three words, in phase order.
- R3: The first word applied after an accepted start has sequential mode 1, rank code 1, rows 16 and page exponent 9. No probe is issued before it.
- R4: Row phase: candidates 11, 12, 13, 14 and 15 are probed in that order at address 1 << (rows + 9). The search stops at the first match. If no candidate matches, the result is 16.
- R5: The second word applied has sequential mode 1, rank code 1, rows 11 and page exponent 13. It comes after the last row probe and before the first column probe.
- R6: Column phase: exponents 9, 10, 11 and 12 are probed in that order at address 1 << exponent. The search stops at the first match. If none matches, the result is 13.
- R7: The third word has sequential mode 0, the rank code captured at start, and the detected rows and page exponent. done_o is 1 in exactly that apply cycle and only for one cycle.
- R8: After done_o, rows_o shows the detected rows and page_size_o equals 1 << page exponent. capacity_o equals page_size × (bus16_i ? 2 : 1) × 2^(bank_i + rank_i + rows).
- R9: Each probe request lasts exactly one cycle. probe_match_i is used only in a cycle where probe_done_i is 1. A done that arrives in the last cycle of the timeout window is still taken.
- R10: If probe_done_i does not arrive within TIMEOUT_CYC cycles after the request, the probe counts as no match and the search moves on.
- R11: A start pulse is ignored while busy_o is 1. This includes the cycle in which done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| rank_i | input | 2 | Rank code to restore in the final word |
| bank_i | input | 1 | Bank code |
| bus16_i | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| cfg_o | output | 14 | Controller configuration word (layout in R2) |
| cfg_apply_o | output | 1 | cfg_o is to be applied in this cycle |
| probe_addr_o | output | 32 | Alias-test address |
| probe_req_o | output | 1 | One-cycle probe request |
| probe_done_i | input | 1 | Probe answer strobe |
| probe_match_i | input | 1 | Probe address aliases address zero (valid with done) |
| busy_o | output | 1 | Detection in progress |
| done_o | output | 1 | One-cycle pulse with the final apply |
| rows_o | output | 5 | Detected row count |
| page_size_o | output | 14 | Detected page size in bytes |
| capacity_o | output | 40 | Total capacity in bytes |

## Verification
Two events can land in the same cycle. One is the alias port's done strobe. The other is the expiry of the block's own timeout window. The bench answers every probe with a delay of exactly TIMEOUT_CYC cycles, so each done arrives in the last cycle of the window. It then checks that the matches are honoured and that the geometry comes out the same as it does with prompt answers. A second coincidence is a start pulse in the same cycle as done_o. The bench checks that this pulse produces no further configuration writes and no further probes.

// File: rtl/geo_pkg.sv
package geo_pkg;
  localparam int ROWS_W     = 5;
  localparam int PEXP_W     = 4;
  localparam int RANK_W     = 2;
  localparam int ROW_FIRST  = 11;
  localparam int ROW_LAST   = 15;
  localparam int ROW_NONE   = 16;
  localparam int ROW_PEXP   = 9;   // page 512 during row search
  localparam int COL_FIRST  = 9;
  localparam int COL_LAST   = 12;
  localparam int COL_NONE   = 13;
  localparam int COL_ROWS   = 11;
  localparam int COL_PEXP   = 13;  // page 8192 during column search
  localparam int PROBE_RANK = 1;
  localparam int PAGE_W     = COL_PEXP + 1;

  typedef struct packed {
    logic              bus16;
    logic              bank;
    logic [PEXP_W-1:0] pexp;
    logic [ROWS_W-1:0] rows;
    logic [RANK_W-1:0] rank;
    logic              seq;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW_CFG, S_ROW_REQ, S_ROW_WAIT,
    S_COL_CFG, S_COL_REQ, S_COL_WAIT, S_FIN
  } st_e;
endpackage

// File: rtl/geo_timer.sv
module geo_timer #(
  parameter int TIMEOUT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/geo_capacity.sv
module geo_capacity #(
  parameter int CAP_W = 40
) (
  input  logic [geo_pkg::PEXP_W-1:0] pexp_i,
  input  logic [geo_pkg::ROWS_W-1:0] rows_i,
  input  logic [geo_pkg::RANK_W-1:0] rank_i,
  input  logic                       bank_i,
  input  logic                       bus16_i,
  output logic [geo_pkg::PAGE_W-1:0] page_size_o,
  output logic [CAP_W-1:0]           capacity_o
);
  localparam int SH_W = 7;
  logic [SH_W-1:0] sh;

  // every factor is a power of two, so capacity is a single shift
  assign sh = SH_W'(pexp_i) + SH_W'(bus16_i) + SH_W'(bank_i) + SH_W'(rank_i) + SH_W'(rows_i);
  assign page_size_o = geo_pkg::PAGE_W'(1) << pexp_i;
  assign capacity_o  = CAP_W'(1) << sh;
endmodule

// File: rtl/geo_search_fsm.sv
module geo_search_fsm #(
  parameter int ADDR_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [geo_pkg::RANK_W-1:0] rank_i,
  input  logic                       bank_i,
  input  logic                       bus16_i,
  input  logic                       probe_done_i,
  input  logic                       probe_match_i,
  input  logic                       tmo_i,
  output logic                       wait_o,
  output geo_pkg::cfg_t              cfg_o,
  output logic                       cfg_apply_o,
  output logic [ADDR_W-1:0]          probe_addr_o,
  output logic                       probe_req_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [geo_pkg::ROWS_W-1:0] rows_o,
  output logic [geo_pkg::PEXP_W-1:0] pexp_o,
  output logic [geo_pkg::RANK_W-1:0] rank_o,
  output logic                       bank_o,
  output logic                       bus16_o
);
  import geo_pkg::*;

  st_e               st_q;
  logic [ROWS_W-1:0] cand_q;
  logic [ROWS_W-1:0] rows_q;
  logic [PEXP_W-1:0] pexp_q;
  logic [RANK_W-1:0] rank_q;
  logic              bank_q, bus16_q;

  logic resolved, hit, row_ph, col_ph;
  assign resolved = probe_done_i | tmo_i;   // done wins over expiry
  assign hit      = probe_done_i & probe_match_i;
  assign row_ph   = (st_q == S_ROW_CFG) || (st_q == S_ROW_REQ) || (st_q == S_ROW_WAIT);
  assign col_ph   = (st_q == S_COL_CFG) || (st_q == S_COL_REQ) || (st_q == S_COL_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cand_q  <= '0;
      rows_q  <= '0;
      pexp_q  <= '0;
      rank_q  <= '0;
      bank_q  <= 1'b0;
      bus16_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          rank_q  <= rank_i;
          bank_q  <= bank_i;
          bus16_q <= bus16_i;
          cand_q  <= ROWS_W'(ROW_FIRST);
          st_q    <= S_ROW_CFG;
        end
        S_ROW_CFG: st_q <= S_ROW_REQ;
        S_ROW_REQ: st_q <= S_ROW_WAIT;
        S_ROW_WAIT: if (resolved) begin
          if (hit || cand_q == ROWS_W'(ROW_LAST)) begin
            rows_q <= hit ? cand_q : ROWS_W'(ROW_NONE);
            cand_q <= ROWS_W'(COL_FIRST);
            st_q   <= S_COL_CFG;
          end else begin
            cand_q <= cand_q + 1'b1;
            st_q   <= S_ROW_REQ;
          end
        end
        S_COL_CFG: st_q <= S_COL_REQ;
        S_COL_REQ: st_q <= S_COL_WAIT;
        S_COL_WAIT: if (resolved) begin
          if (hit || cand_q == ROWS_W'(COL_LAST)) begin
            pexp_q <= hit ? PEXP_W'(cand_q) : PEXP_W'(COL_NONE);
            st_q   <= S_FIN;
          end else begin
            cand_q <= cand_q + 1'b1;
            st_q   <= S_COL_REQ;
          end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_o       = '0;
    cfg_o.bus16 = bus16_q;
    cfg_o.bank  = bank_q;
    if (row_ph) begin
      cfg_o.seq  = 1'b1;
      cfg_o.rank = RANK_W'(PROBE_RANK);
      cfg_o.rows = ROWS_W'(ROW_NONE);
      cfg_o.pexp = PEXP_W'(ROW_PEXP);
    end else if (col_ph) begin
      cfg_o.seq  = 1'b1;
      cfg_o.rank = RANK_W'(PROBE_RANK);
      cfg_o.rows = ROWS_W'(COL_ROWS);
      cfg_o.pexp = PEXP_W'(COL_PEXP);
    end else begin
      cfg_o.seq  = 1'b0;
      cfg_o.rank = rank_q;
      cfg_o.rows = rows_q;
      cfg_o.pexp = pexp_q;
    end
  end

  logic [5:0] addr_sh;
  assign addr_sh = row_ph ? (6'(cand_q) + 6'(ROW_PEXP)) : 6'(cand_q);

  assign probe_addr_o = ADDR_W'(1) << addr_sh;
  assign probe_req_o  = (st_q == S_ROW_REQ) || (st_q == S_COL_REQ);
  assign wait_o       = (st_q == S_ROW_WAIT) || (st_q == S_COL_WAIT);
  assign cfg_apply_o  = (st_q == S_ROW_CFG) || (st_q == S_COL_CFG) || (st_q == S_FIN);
  assign done_o       = (st_q == S_FIN);
  assign busy_o       = (st_q != S_IDLE);
  assign rows_o       = rows_q;
  assign pexp_o       = pexp_q;
  assign rank_o       = rank_q;
  assign bank_o       = bank_q;
  assign bus16_o      = bus16_q;
endmodule

// File: rtl/geo_probe_seq.sv
module geo_probe_seq #(
  parameter int ADDR_W      = 32,
  parameter int CAP_W       = 40,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [geo_pkg::RANK_W-1:0] rank_i,
  input  logic                       bank_i,
  input  logic                       bus16_i,
  output logic [geo_pkg::CFG_W-1:0]  cfg_o,
  output logic                       cfg_apply_o,
  output logic [ADDR_W-1:0]          probe_addr_o,
  output logic                       probe_req_o,
  input  logic                       probe_done_i,
  input  logic                       probe_match_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [geo_pkg::ROWS_W-1:0] rows_o,
  output logic [geo_pkg::PAGE_W-1:0] page_size_o,
  output logic [CAP_W-1:0]           capacity_o
);
  import geo_pkg::*;

  logic              wait_s, tmo_s, bank_s, bus16_s;
  cfg_t              cfg_s;
  logic [PEXP_W-1:0] pexp_s;
  logic [RANK_W-1:0] rank_s;

  geo_search_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .rank_i, .bank_i, .bus16_i,
    .probe_done_i, .probe_match_i,
    .tmo_i        (tmo_s),
    .wait_o       (wait_s),
    .cfg_o        (cfg_s),
    .cfg_apply_o, .probe_addr_o, .probe_req_o, .busy_o, .done_o, .rows_o,
    .pexp_o       (pexp_s),
    .rank_o       (rank_s),
    .bank_o       (bank_s),
    .bus16_o      (bus16_s)
  );

  geo_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .run_i     (wait_s),
    .expired_o (tmo_s)
  );

  geo_capacity #(.CAP_W(CAP_W)) u_cap (
    .pexp_i      (pexp_s),
    .rows_i      (rows_o),
    .rank_i      (rank_s),
    .bank_i      (bank_s),
    .bus16_i     (bus16_s),
    .page_size_o,
    .capacity_o
  );

  assign cfg_o = cfg_s;
endmodule

// File: rtl/geo_probe_seq_chk.sv
module geo_probe_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [geo_pkg::CFG_W-1:0]  cfg_o,
  input logic                       cfg_apply_o,
  input logic [ADDR_W-1:0]          probe_addr_o,
  input logic                       probe_req_o,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [geo_pkg::ROWS_W-1:0] rows_o,
  input logic [geo_pkg::PAGE_W-1:0] page_size_o
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |=> !probe_req_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_FINAL_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cfg_apply_o && !cfg_o[0])); // R7
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |-> ($countones(probe_addr_o) == 1)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!probe_req_o && !cfg_apply_o)); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R11
  AST_ROWS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rows_o >= 5'd11 && rows_o <= 5'd16)); // R4
  AST_PAGE_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(page_size_o) == 1 && page_size_o >= 14'd512)); // R8
  AST_PROBE_CFG_ROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_apply_o && cfg_o[0]) |-> (cfg_o[7:3] == 5'd16 || cfg_o[7:3] == 5'd11)); // R3
endmodule

bind geo_probe_seq geo_probe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/geo_probe_seq_bench.sv
module geo_probe_seq_bench;
  localparam int T = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  rank_i = 2'd0;
  logic        bank_i = 1'b0;
  logic        bus16_i = 1'b0;
  logic        probe_done_i, probe_match_i;
  logic [13:0] cfg_o;
  logic        cfg_apply_o, probe_req_o, busy_o, done_o;
  logic [31:0] probe_addr_o;
  logic [4:0]  rows_o;
  logic [13:0] page_size_o;
  logic [39:0] capacity_o;

  always #5 clk = ~clk;

  geo_probe_seq u_geo_probe_seq (
    .clk_i(clk), .rst_ni, .start_i, .rank_i, .bank_i, .bus16_i,
    .cfg_o, .cfg_apply_o, .probe_addr_o, .probe_req_o,
    .probe_done_i, .probe_match_i, .busy_o, .done_o,
    .rows_o, .page_size_o, .capacity_o
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // memory model and responder settings
  int mem_r = 13, mem_c = 10, dly = 1;
  bit mute = 0;

  logic [13:0] apply_log [8];
  logic [31:0] probe_log [16];
  int n_apply = 0, n_probe = 0, n_done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_of(input logic [31:0] a);
    int e = -1;
    for (int i = 0; i < 32; i++) if (a[i]) e = i;
    return e;
  endfunction

  function automatic logic [13:0] mkcfg(input bit bus, input bit bk, input int pexp,
                                        input int rows, input int rk, input bit seq);
    return {bus, bk, 4'(pexp), 5'(rows), 2'(rk), seq};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (cfg_apply_o) begin
      if (n_apply < 8) apply_log[n_apply] = cfg_o;
      n_apply++;
    end
    if (probe_req_o) begin
      if (n_probe < 16) probe_log[n_probe] = probe_addr_o;
      n_probe++;
    end
    if (done_o) n_done++;
  end

  // alias-test responder
  initial begin
    probe_done_i = 1'b0;
    probe_match_i = 1'b0;
    forever begin
      @(negedge clk);
      probe_done_i = 1'b0;
      probe_match_i = 1'b0;
      if (probe_req_o && !mute) begin
        int e;
        e = exp_of(probe_addr_o);
        repeat (dly) @(negedge clk);
        probe_match_i = (e >= 20) ? ((e - 9) >= mem_r) : (e >= mem_c);
        probe_done_i = 1'b1;
      end
    end
  end

  // one detection run plus all its checks
  task automatic run_case(input string name, input int r, input int c, input int d,
                          input bit m, input int rk, input bit bk, input bit bus,
                          input bit extra_start);
    int er, ec, np, guard;
    logic [31:0] exp_probe [16];
    longint exp_cap;
    mem_r = r; mem_c = c; dly = d; mute = m;
    rank_i = 2'(rk); bank_i = bk; bus16_i = bus;
    er = m ? 16 : (r > 15 ? 16 : r);
    ec = m ? 13 : (c > 12 ? 13 : c);
    np = 0;
    for (int i = 11; i <= 15; i++) begin
      exp_probe[np] = 32'(1) << (i + 9); np++;
      if (i >= er) break;
    end
    for (int i = 9; i <= 12; i++) begin
      exp_probe[np] = 32'(1) << i; np++;
      if (i >= ec) break;
    end
    @(negedge clk);
    n_apply = 0; n_probe = 0; n_done = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (extra_start) begin
      repeat (4) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    start_i = 1'b1;  // coincides with done_o
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    $display("[TB] case %s", name);
    chk(n_done == 1, "R7 done count", n_done, 1);
    chk(n_apply == 3, "R2 R11 apply count", n_apply, 3);
    chk(busy_o == 1'b0, "R11 idle after run", busy_o, 0);
    chk(apply_log[0] == mkcfg(bus, bk, 9, 16, 1, 1), "R3 row cfg", apply_log[0], mkcfg(bus, bk, 9, 16, 1, 1));
    chk(apply_log[1] == mkcfg(bus, bk, 13, 11, 1, 1), "R5 col cfg", apply_log[1], mkcfg(bus, bk, 13, 11, 1, 1));
    chk(apply_log[2] == mkcfg(bus, bk, ec, er, rk, 0), "R7 final cfg", apply_log[2], mkcfg(bus, bk, ec, er, rk, 0));
    chk(n_probe == np, "R4 R6 probe count", n_probe, np);
    for (int i = 0; i < np && i < n_probe; i++)
      chk(probe_log[i] == exp_probe[i], "R4 R6 probe order", probe_log[i], exp_probe[i]);
    chk(rows_o == 5'(er), "R4 rows", rows_o, er);
    chk(page_size_o == 14'(1 << ec), "R6 R8 page size", page_size_o, 1 << ec);
    exp_cap = longint'(1) << (ec + (bus ? 1 : 0) + bk + rk + er);
    chk(capacity_o == exp_cap[39:0], "R8 capacity", capacity_o, exp_cap);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy_o && !done_o && !probe_req_o && !cfg_apply_o, "R1 in reset",
        {busy_o, done_o, probe_req_o, cfg_apply_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !probe_req_o && !cfg_apply_o, "R1 after reset",
        {busy_o, done_o, probe_req_o, cfg_apply_o}, 0);
  endtask

  initial begin
    t_reset();
    run_case("mid",            13, 10, 1, 0, 1, 1, 1, 0); // R4 R6 R8
    run_case("first_hit",      11,  9, 2, 0, 2, 0, 0, 0); // R4 R6
    run_case("no_hit",         16, 13, 3, 0, 1, 1, 1, 0); // R4 R6 none match
    run_case("done_at_expiry", 12, 12, T, 0, 3, 0, 1, 0); // R9
    run_case("all_timeout",    12, 10, 1, 1, 2, 1, 0, 0); // R10
    run_case("restart_busy",   14, 11, 2, 0, 1, 0, 1, 1); // R11
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule